// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a packet DMA engine. It takes an incoming byte stream that carries frame start and end markers and stores each frame in memory. Memory holds a ring of two-word descriptors. The first word of a descriptor gives the address of a fixed 128-byte data buffer and carries an ownership bit and a ring-end bit. The second word is a status word that the engine writes when it finishes with the buffer. A frame longer than one buffer spills into the following descriptors, and it may run past the ring end back to the base. Only the last buffer of a frame records the frame length and the per-frame match flags.

The engine reads a descriptor's address word before it fills that buffer. A buffer still owned by software is never written. When that happens, the rest of the frame is thrown away and a one-cycle no-buffer pulse is raised. When a buffer is done, the engine writes the status word first and then rewrites the address word with the ownership bit set, which hands the buffer to software. Software returns a buffer by clearing that bit again. The ring base pointer is taken from an input while reset is active.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the engine is idle: no memory request is driven, `nobuf` is low, `in_ready` is high while no start-of-frame byte is offered, and the first descriptor used is the one at `ring_base`.
- R2: At the start of a frame the engine reads the address word of the current descriptor. If bit 0 of that word is 1, the whole frame is consumed and discarded with no memory write, `nobuf` pulses for exactly one cycle, and the next frame uses the same descriptor again.
- R3: Buffer data is stored little-endian. Frame byte k of a buffer goes to byte address P + k, where P is the address word with bits 1:0 cleared. The engine uses one full-width write per 4-byte group, and its byte enables cover only the bytes received. A byte past the end of the frame in a partly filled word is left unchanged.
- R4: Each buffer takes exactly 128 bytes. The 129th byte of a frame goes to the next descriptor's buffer.
- R5: When a buffer is complete, the engine writes the status word (descriptor address + 4) and after that rewrites the address word with bit 0 set and all other bits kept.
- R6: Status bit 14 is set only in the first buffer of a frame. Bit 15 is set only in the last buffer. Bits 11:0 hold the total frame length in bytes in the last buffer and are zero in every other buffer.
- R7: In the last buffer only, the `in_flags` value present with the end-of-frame byte is recorded as follows: flag 0 (broadcast) goes to status bit 31, flag 1 (type match) to bit 22, and flags 2, 3, 4 and 5 (address match 1 to 4) to bits 26, 25, 24 and 23.
- R8: After a descriptor whose address word has bit 1 set, the next descriptor used is the one at `ring_base`. Otherwise the next descriptor is 8 bytes further on. A single frame may cross this wrap.
- R9: If a descriptor after the first one of a frame is still software-owned, the remaining bytes of the frame are discarded and `nobuf` pulses once. Buffers already completed keep their written state, which has no last-buffer flag.
- R10: Bytes offered while idle without a start-of-frame marker are accepted and ignored, with no memory access.
- R11: `in_ready` is low while a descriptor is being read or written back, including the cycle in which a start-of-frame byte first appears while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the ring base |
| ring_base | input | AW | Byte address of the first descriptor, 8-byte aligned |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_flags | input | 6 | Per-frame match flags, sampled with the end-of-frame byte |
| in_ready | output | 1 | Byte accepted on a clock edge when high together with in_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid in the cycle after the read request |
| nobuf | output | 1 | One-cycle pulse: a frame or frame tail was discarded for lack of a buffer |

## Verification
The hardest case to produce is a descriptor that is still owned by software when it is reached in the middle of a frame. Neither the start of the frame nor the stream interface shows that this case is coming. The bench produces it in two ways. A directed 600-byte frame fills the whole four-entry ring and wraps back onto the buffer it just filled. In the random phase, each returned buffer is released only with some probability, which leaves holes at arbitrary ring positions under frames of random length. A bench model predicts which buffers are filled, the pulse count and the exact number of memory writes.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int WORD_W    = 32;
  localparam int NFLAGS    = 6;
  localparam int LEN_BITS  = 12;

  // address word bits
  localparam int OWN_BIT   = 0;
  localparam int WRAP_BIT  = 1;

  // status word bits
  localparam int ST_FIRST  = 14;
  localparam int ST_LAST   = 15;
  localparam int ST_BCAST  = 31;
  localparam int ST_TYPE   = 22;
  localparam int ST_ADR1   = 26;  // address match k lands at ST_ADR1 - (k-1)
  localparam int NADR      = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDADDR,
    ST_WAITRD,
    ST_CHKADDR,
    ST_FILL,
    ST_WRSTAT,
    ST_WRADDR,
    ST_DROP
  } rxr_state_t;

endpackage

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer #(
  parameter int LANES = 4,
  localparam int LW   = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic [LW-1:0]      lane,
  input  logic [7:0]         byte_in,
  input  logic               flush,
  output logic [8*LANES-1:0] word_out,
  output logic [LANES-1:0]   be_out
);

  logic [8*LANES-1:0] acc;
  logic [LANES-1:0]   be;
  logic [LANES-1:0]   hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hit[l]            = take && (lane == LW'(l));
    assign word_out[8*l +: 8] = hit[l] ? byte_in : acc[8*l +: 8];
    assign be_out[l]          = be[l] | hit[l];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      be  <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (hit[l]) acc[8*l +: 8] <= byte_in;
      end
      if (flush) be <= '0;
      else       be <= be | hit;
    end
  end

  // a flushed word always carries at least the byte that triggered it
  AST_FLUSH_HAS_BYTE: assert property (@(posedge clk) disable iff (rst)
    flush |-> (be_out != '0)); // R3

endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic          step,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst)       ptr <= base;
    else if (step) ptr <= wrap ? base : ptr + AW'(DESC_BYTES);
  end

  AST_PTR_RETURN: assert property (@(posedge clk) disable iff (rst)
    (step && wrap) |=> (ptr == $past(base))); // R8

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ptr)); // R2

endmodule

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt
  import rxr_pkg::*;
(
  input  logic                first,
  input  logic                last,
  input  logic [LEN_BITS-1:0] len,
  input  logic [NFLAGS-1:0]   flags,
  output logic [WORD_W-1:0]   word
);

  always_comb begin
    word           = '0;
    word[ST_FIRST] = first;
    if (last) begin
      word[ST_LAST]         = 1'b1;
      word[LEN_BITS-1:0]    = len;
      word[ST_BCAST]        = flags[0];
      word[ST_TYPE]         = flags[1];
      for (int k = 0; k < NADR; k++) begin
        word[ST_ADR1 - k] = flags[2 + k];
      end
    end
  end

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     ring_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [5:0]        in_flags,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  output logic              nobuf
);

  localparam int DW         = WORD_W;
  localparam int LANES      = DW / 8;
  localparam int LW         = $clog2(LANES);
  localparam int OFF_W      = $clog2(BUF_BYTES);
  localparam int DESC_BYTES = 2 * LANES;

  rxr_state_t          state;
  logic [DW-1:0]       addr_word;
  logic [OFF_W-1:0]    off;
  logic [LEN_BITS-1:0] flen;
  logic [NFLAGS-1:0]   flags_q;
  logic                first;
  logic                last;

  logic [AW-1:0]       desc_ptr;
  logic [AW-1:0]       buf_base;
  logic [OFF_W-1:0]    word_off;
  logic [DW-1:0]       pk_word;
  logic [LANES-1:0]    pk_be;
  logic [DW-1:0]       st_word;
  logic                take;
  logic                flush;
  logic                buf_end;
  logic                step;

  // ---------------- stream side ----------------
  assign in_ready = (state == ST_FILL) || (state == ST_DROP) ||
                    ((state == ST_IDLE) && !in_sof);
  assign take     = in_valid && in_ready && (state == ST_FILL);
  assign buf_end  = (off == OFF_W'(BUF_BYTES - 1));
  assign flush    = take && ((off[LW-1:0] == LW'(LANES - 1)) || in_eof);

  assign buf_base = AW'({addr_word[DW-1:2], 2'b00});
  assign word_off = {off[OFF_W-1:LW], {LW{1'b0}}};
  assign step     = (state == ST_WRADDR);

  rxr_byte_packer #(.LANES(LANES)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .lane     (off[LW-1:0]),
    .byte_in  (in_data),
    .flush    (flush),
    .word_out (pk_word),
    .be_out   (pk_be)
  );

  rxr_ring_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .base (ring_base),
    .step (step),
    .wrap (addr_word[WRAP_BIT]),
    .ptr  (desc_ptr)
  );

  rxr_status_fmt u_stat (
    .first (first),
    .last  (last),
    .len   (flen),
    .flags (flags_q),
    .word  (st_word)
  );

  // ---------------- control and registered memory port ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
      nobuf     <= 1'b0;
      addr_word <= '0;
      off       <= '0;
      flen      <= '0;
      flags_q   <= '0;
      first     <= 1'b0;
      last      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      nobuf   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid && in_sof) begin
            first <= 1'b1;
            last  <= 1'b0;
            flen  <= '0;
            state <= ST_RDADDR;
          end
        end
        ST_RDADDR: begin
          mem_req  <= 1'b1;
          mem_addr <= desc_ptr;
          mem_be   <= '0;
          state    <= ST_WAITRD;
        end
        ST_WAITRD: state <= ST_CHKADDR;
        ST_CHKADDR: begin
          if (mem_rdata[OWN_BIT]) begin
            nobuf <= 1'b1;
            state <= ST_DROP;
          end else begin
            addr_word <= mem_rdata;
            off       <= '0;
            state     <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (take) begin
            flen <= flen + 1'b1;
            off  <= off + 1'b1;
            if (flush) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= buf_base + AW'(word_off);
              mem_wdata <= pk_word;
              mem_be    <= pk_be;
            end
            if (in_eof) begin
              last    <= 1'b1;
              flags_q <= in_flags;
            end
            if (in_eof || buf_end) state <= ST_WRSTAT;
          end
        end
        ST_WRSTAT: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= desc_ptr + AW'(LANES);
          mem_wdata <= st_word;
          mem_be    <= '1;
          state     <= ST_WRADDR;
        end
        ST_WRADDR: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= desc_ptr;
          mem_wdata <= addr_word | DW'(1);
          mem_be    <= '1;
          first     <= 1'b0;
          state     <= last ? ST_IDLE : ST_RDADDR;
        end
        ST_DROP: begin
          if (in_valid && in_eof) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_STALL_ON_DESC: assert property (@(posedge clk) disable iff (rst)
    (state inside {ST_RDADDR, ST_WAITRD, ST_CHKADDR, ST_WRSTAT, ST_WRADDR}) |-> !in_ready); // R11

  AST_OWN_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRADDR) |=> (mem_req && mem_we && mem_wdata[OWN_BIT] && (mem_be == '1))); // R5

  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRADDR) |-> ($past(state) == ST_WRSTAT)); // R5

  AST_WRITE_HAS_BE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_be != '0)); // R3

  AST_NOBUF_PULSE: assert property (@(posedge clk) disable iff (rst)
    nobuf |=> !nobuf); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && $past(state) == ST_IDLE) |-> !mem_req); // R10

endmodule

// File: tb/rxr_ring_writer_tb.sv
`timescale 1ns/100ps
module rxr_ring_writer_tb;

  localparam int AW    = 32;
  localparam int RB    = 32'h100;
  localparam int BUFB  = 32'h400;
  localparam int NDESC = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic [5:0]  in_flags;
  logic        in_ready;
  logic        mem_req, mem_we, nobuf;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic        sw_we = 1'b0;
  logic [31:0] sw_addr = '0, sw_data = '0;
  logic [31:0] mem [0:511];
  int n_wr = 0, n_rd = 0, n_nobuf = 0;
  int checks = 0, errors = 0;
  int e_idx = 0;
  logic [7:0] fb [0:1023];

  always #2.5 clk = ~clk;

  rxr_ring_writer #(.AW(AW), .BUF_BYTES(128)) u_dut (
    .clk(clk), .rst(rst), .ring_base(RB),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_flags(in_flags), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .nobuf(nobuf)
  );

  // memory model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 512; i++) mem[i] <= '0;
    end else begin
      if (sw_we) mem[sw_addr[10:2]] <= sw_data;
      if (mem_req) begin
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
          n_wr <= n_wr + 1;
        end else begin
          mem_rdata <= mem[mem_addr[10:2]];
          n_rd <= n_rd + 1;
        end
      end
      if (nobuf) n_nobuf <= n_nobuf + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic sw_write(input int a, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = a; sw_data = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  function automatic logic [31:0] addr_val(input int i);
    return (BUFB + 128 * i) | ((i == NDESC - 1) ? 32'h2 : 32'h0);
  endfunction

  function automatic logic [31:0] flag_bits(input logic [5:0] fl);
    logic [31:0] w = '0;
    w[31] = fl[0]; w[22] = fl[1];
    w[26] = fl[2]; w[25] = fl[3]; w[24] = fl[4]; w[23] = fl[5];
    return w;
  endfunction

  task automatic release_desc(input int i);
    sw_write(RB + 8 * i, addr_val(i));
    sw_write(RB + 8 * i + 4, 32'h0);
    for (int w = 0; w < 32; w++) sw_write(BUFB + 128 * i + 4 * w, 32'hEEEE_EEEE);
  endtask

  task automatic release_owned(input int pct);
    for (int i = 0; i < NDESC; i++)
      if (mem[(RB >> 2) + 2 * i][0] && (($urandom % 100) < pct)) release_desc(i);
  endtask

  task automatic send_frame(input int len, input logic [5:0] fl, input int gap);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb[k];
      in_sof = (k == 0); in_eof = (k == len - 1);
      in_flags = (k == len - 1) ? fl : ~fl;
      #1;
      if (k == 0) chk(in_ready == 1'b0, "R11", "ready with fresh start byte", 32'(in_ready), 0);
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      if (($urandom % 100) < gap) begin @(negedge clk); in_valid = 1'b0; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic run_frame(input int len, input logic [5:0] fl, input int gap);
    bit own [NDESC];
    int bidx [8], bcnt [8];
    int nb = 0, rem = len, idx = e_idx, expw = 0, w0, p0, errs;
    bit dropped = 0;
    for (int i = 0; i < NDESC; i++) own[i] = mem[(RB >> 2) + 2 * i][0];
    while (rem > 0) begin
      if (own[idx]) begin dropped = 1; break; end
      bcnt[nb] = (rem > 128) ? 128 : rem;
      bidx[nb] = idx; own[idx] = 1;
      expw += (bcnt[nb] + 3) / 4 + 2;
      rem -= bcnt[nb]; nb++;
      idx = (idx == NDESC - 1) ? 0 : idx + 1;
    end
    for (int k = 0; k < len; k++) fb[k] = 8'($urandom);
    w0 = n_wr; p0 = n_nobuf;
    send_frame(len, fl, gap);
    repeat (10) @(negedge clk);
    chk((n_nobuf - p0) == int'(dropped), (dropped && nb > 0) ? "R9" : "R2",
        "nobuf pulses", n_nobuf - p0, int'(dropped));
    chk((n_wr - w0) == expw, (nb == 0) ? "R2" : "R3", "memory writes", n_wr - w0, expw);
    for (int j = 0; j < nb; j++) begin
      int a = RB + 8 * bidx[j];
      int base = BUFB + 128 * bidx[j];
      bit is_last = (j == nb - 1) && !dropped;
      logic [31:0] exp_st = ((j == 0) ? 32'h4000 : 32'h0) |
        (is_last ? (32'h8000 | 32'(len[11:0]) | flag_bits(fl)) : 32'h0);
      chk(mem[(a + 4) >> 2] == exp_st, "R6 R7", "status word", mem[(a + 4) >> 2], exp_st);
      chk(mem[a >> 2] == (addr_val(bidx[j]) | 32'h1), (bidx[j] == NDESC - 1) ? "R8" : "R5",
          "address word", mem[a >> 2], addr_val(bidx[j]) | 32'h1);
      errs = 0;
      for (int b = 0; b < bcnt[j]; b++)
        if (mem[(base + b) >> 2][8 * ((base + b) % 4) +: 8] != fb[j * 128 + b]) errs++;
      if (bcnt[j] % 4 != 0)
        if (mem[(base + bcnt[j]) >> 2][8 * (bcnt[j] % 4) +: 8] != 8'hEE) errs++;
      chk(errs == 0, (bcnt[j] == 128) ? "R4" : "R3", "buffer bytes mismatched", errs, 0);
    end
    e_idx = idx;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int w0, r0;
    void'($urandom(32'd4242));
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0; in_flags = 0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R1", "ready after reset", 32'(in_ready), 1);
    chk(mem_req == 1'b0, "R1", "memory request after reset", 32'(mem_req), 0);
    chk(nobuf == 1'b0, "R1", "nobuf after reset", 32'(nobuf), 0);
    for (int i = 0; i < NDESC; i++) release_desc(i);

    // R10: stray bytes while idle
    w0 = n_wr; r0 = n_rd;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(k); in_eof = (k == 3); #1;
      chk(in_ready == 1'b1, "R10", "stray byte accepted", 32'(in_ready), 1);
    end
    @(negedge clk); in_valid = 0; in_eof = 0;
    repeat (4) @(negedge clk);
    chk((n_wr - w0) + (n_rd - r0) == 0, "R10", "memory accesses for stray bytes",
        (n_wr - w0) + (n_rd - r0), 0);

    // directed lengths (R1: first frame lands at ring base)
    run_frame(1,   6'h01, 0);  release_owned(100);
    run_frame(5,   6'h3C, 0);  release_owned(100);
    run_frame(128, 6'h02, 10); release_owned(100);
    run_frame(129, 6'h20, 0);  release_owned(100);
    run_frame(300, 6'h15, 20); release_owned(100);

    // R2: software-owned first descriptor
    sw_write(RB + 8 * e_idx, addr_val(e_idx) | 32'h1);
    run_frame(40, 6'h0F, 0);
    release_owned(100);
    run_frame(7, 6'h2A, 0);    release_owned(100);

    // R9: oversize frame wraps onto its own first buffer
    run_frame(600, 6'h3F, 5);  release_owned(100);

    // random phase with partial release
    for (int f = 0; f < 30; f++) begin
      run_frame(1 + ($urandom % 400), 6'($urandom), 20);
      release_owned(75);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule